// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block sits between the load/store port of one processor core and a small synchronous word memory. Besides plain loads and stores it serves a reserving load, which reads a word and arms a reservation on the 64-byte line holding that word. It also serves a conditional store, which writes only while that reservation is still intact and returns a one-bit status: 0 when the write took place, 1 when it was refused.

The block holds exactly one reservation. A write address from another agent that falls anywhere inside the reserved line breaks it, and so does a trap or interrupt pulse from the core. The core's own plain stores to that line break it as well. Every conditional store consumes the reservation whatever its outcome, so software retries with a fresh reserving load. One request is accepted per cycle, and each one is answered by a single-cycle ready pulse on the following cycle.

Top module: `lrsc_monitor`

## Requirements
- R1: A reserving load (opcode 2'b10) returns the addressed word one cycle later and arms a reservation on the line numbered by the address bits above bit 5.
- R2: A conditional store (opcode 2'b11) writes the word only when a reservation is armed on the line its own address falls in; a refused one leaves memory unchanged.
- R3: The status output reads 0 for a conditional store that wrote and 1 for one that was refused; it reads 0 with every other response.
- R4: A snoop write strobe whose address falls anywhere in the reserved line breaks the reservation; a snoop to any other line leaves it intact.
- R5: Every conditional store disarms the reservation, whether or not it wrote.
- R6: A new reserving load replaces any earlier reservation, so only the newest line is held.
- R7: A pulse on the trap clear input disarms the reservation, and a conditional store in that same cycle is refused.
- R8: A plain store (opcode 2'b01) from the core to the reserved line disarms it; a plain store to another line does not.
- R9: Every accepted request yields a one-cycle ready pulse in the following cycle, carrying the read word for loads (opcode 2'b00) and reserving loads and zero for either kind of store; ready stays low after idle cycles.
- R10: A snoop to the reserved line in the same cycle as a conditional store to that line takes effect first, so the store is refused and memory is unchanged.
- R11: After reset no reservation is armed, ready is low and every memory word reads zero.
- R12: The two low address bits select nothing; any byte address in a word reaches that word, and any address in a line matches that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 reserving load, 11 conditional store |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Data to write for either kind of store |
| snoop_we | input | 1 | Another agent writes this cycle |
| snoop_addr | input | ADDR_W | Byte address of that write |
| resv_clear | input | 1 | Trap or interrupt pulse that disarms the reservation |
| rsp_ready | output | 1 | Response pulse, one cycle after a request |
| rsp_rdata | output | DATA_W | Read word for loads, zero otherwise |
| rsp_sc_fail | output | 1 | Conditional store status: 0 wrote, 1 refused |

## Verification
The bench builds the block with a 10-bit byte address, 32-bit words and 64-byte lines. That gives sixteen lines of sixteen words, so neighbouring lines, the byte offsets inside a line and both ends of the address space can all be reached in a short run. A reference model of the memory and the reservation predicts every response. The stimulus places snoops, traps and plain stores both on and off the reserved line, and in the same cycle as conditional stores and reserving loads.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LR    = 2'b10,
      OP_SC    = 2'b11
   } lrsc_op_e;

   function automatic logic is_read(input lrsc_op_e op);
      return (op == OP_LOAD) || (op == OP_LR);
   endfunction

endpackage

// File: rtl/lrsc_word_mem.sv
// Single-port word memory with registered read; read data is zero when no read.
module lrsc_word_mem #(
   parameter int  DATA_W         = 32,
   parameter int  WORDS          = 256,
   parameter bit  CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W          = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] store_q [WORDS];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < WORDS; i++) begin
                  store_q[i] <= '0;
               end
            end else if (wr_en) begin
               store_q[idx] <= wdata;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_en) begin
               store_q[idx] <= wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= store_q[idx];
      end else begin
         rdata <= '0;
      end
   end

endmodule

// File: rtl/lrsc_resv.sv
// Single reservation register with snoop, trap and store kill paths.
module lrsc_resv
   import lrsc_pkg::*;
#(
   parameter int LINE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  lrsc_op_e          req_op,
   input  logic [LINE_W-1:0] req_line,
   input  logic              snoop_we,
   input  logic [LINE_W-1:0] snoop_line,
   input  logic              trap_clr,
   output logic              sc_ok,
   output logic              resv_valid,
   output logic [LINE_W-1:0] resv_line
);

   logic snoop_hits_held;
   logic snoop_hits_new;
   logic req_hits_held;
   logic next_valid;
   logic [LINE_W-1:0] next_line;

   assign snoop_hits_held = snoop_we && (snoop_line == resv_line);
   assign snoop_hits_new  = snoop_we && (snoop_line == req_line);
   assign req_hits_held   = resv_valid && (req_line == resv_line);

   // Snoop and trap are resolved before the store decision.
   assign sc_ok = req_valid && (req_op == OP_SC) && req_hits_held
                  && !snoop_hits_held && !trap_clr;

   always_comb begin
      next_valid = resv_valid;
      next_line  = resv_line;
      if (trap_clr) begin
         next_valid = 1'b0;
      end else if (req_valid && (req_op == OP_LR)) begin
         next_valid = !snoop_hits_new;
         next_line  = req_line;
      end else begin
         if (req_valid && (req_op == OP_SC)) begin
            next_valid = 1'b0;
         end
         if (req_valid && (req_op == OP_STORE) && req_hits_held) begin
            next_valid = 1'b0;
         end
         if (snoop_hits_held) begin
            next_valid = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resv_valid <= 1'b0;
         resv_line  <= '0;
      end else begin
         resv_valid <= next_valid;
         resv_line  <= next_line;
      end
   end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
   import lrsc_pkg::*;
#(
   parameter int  ADDR_W         = 10,
   parameter int  DATA_W         = 32,
   parameter int  LINE_BYTES     = 64,
   parameter bit  CLEAR_ON_RESET = 1'b1,
   localparam int BYTES_W        = DATA_W / 8,
   localparam int OFF_W          = $clog2(BYTES_W),
   localparam int LINE_OFF       = $clog2(LINE_BYTES),
   localparam int LINE_W         = ADDR_W - LINE_OFF,
   localparam int WORDS          = (1 << ADDR_W) / BYTES_W,
   localparam int IDX_W          = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              snoop_we,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic              resv_clear,
   output logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_sc_fail
);

   generate
      if ((DATA_W % 8) != 0 || (1 << OFF_W) != BYTES_W) begin : g_bad_data
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if ((1 << LINE_OFF) != LINE_BYTES || LINE_BYTES < BYTES_W) begin : g_bad_line
         $error("LINE_BYTES must be a power of two no smaller than a word");
      end
      if (LINE_W < 1) begin : g_bad_addr
         $error("ADDR_W must cover more than one line");
      end
   endgenerate

   lrsc_op_e          op;
   logic [LINE_W-1:0] req_line;
   logic [LINE_W-1:0] snoop_line;
   logic [IDX_W-1:0]  word_idx;
   logic              sc_ok;
   logic              resv_valid;
   logic [LINE_W-1:0] resv_line;
   logic              mem_we;
   logic              mem_re;

   assign op         = lrsc_op_e'(req_op);
   assign req_line   = req_addr[ADDR_W-1:LINE_OFF];
   assign snoop_line = snoop_addr[ADDR_W-1:LINE_OFF];
   assign word_idx   = req_addr[ADDR_W-1:OFF_W];

   lrsc_resv #(
      .LINE_W (LINE_W)
   ) u_resv (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (op),
      .req_line   (req_line),
      .snoop_we   (snoop_we),
      .snoop_line (snoop_line),
      .trap_clr   (resv_clear),
      .sc_ok      (sc_ok),
      .resv_valid (resv_valid),
      .resv_line  (resv_line)
   );

   assign mem_we = req_valid && ((op == OP_STORE) || sc_ok);
   assign mem_re = req_valid && is_read(op);

   lrsc_word_mem #(
      .DATA_W         (DATA_W),
      .WORDS          (WORDS),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (mem_we),
      .rd_en (mem_re),
      .idx   (word_idx),
      .wdata (req_wdata),
      .rdata (rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_ready   <= 1'b0;
         rsp_sc_fail <= 1'b0;
      end else begin
         rsp_ready   <= req_valid;
         rsp_sc_fail <= req_valid && (op == OP_SC) && !sc_ok;
      end
   end

endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
   parameter int ADDR_W   = 10,
   parameter int LINE_OFF = 6,
   localparam int LINE_W  = ADDR_W - LINE_OFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [ADDR_W-1:0] req_addr,
   input logic              snoop_we,
   input logic [ADDR_W-1:0] snoop_addr,
   input logic              resv_clear,
   input logic              rsp_ready,
   input logic              rsp_sc_fail,
   input logic              resv_valid,
   input logic [LINE_W-1:0] resv_line
);

   logic is_sc, is_lr;
   logic snoop_on_held, snoop_on_req;
   assign is_sc = req_valid && (req_op == 2'b11);
   assign is_lr = req_valid && (req_op == 2'b10);
   assign snoop_on_held = snoop_we && (snoop_addr[ADDR_W-1:LINE_OFF] == resv_line);
   assign snoop_on_req  = snoop_we && (snoop_addr[ADDR_W-1:LINE_OFF] == req_addr[ADDR_W-1:LINE_OFF]);

   p_ready_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_ready);
   p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_ready);
   p_sc_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_sc |=> !resv_valid);
   p_trap_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resv_clear |=> !resv_valid);
   p_no_resv_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sc && !resv_valid) |=> rsp_sc_fail);
   p_snoop_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sc && snoop_on_held) |=> rsp_sc_fail);
   p_snoop_kills_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_on_held && !is_lr) |=> !resv_valid);
   p_lr_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lr && !resv_clear && !snoop_on_req) |=>
         (resv_valid && resv_line == $past(req_addr[ADDR_W-1:LINE_OFF])));
   p_status_only_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !is_sc) |=> !rsp_sc_fail);

endmodule

bind lrsc_monitor lrsc_monitor_chk #(
   .ADDR_W   (ADDR_W),
   .LINE_OFF (LINE_OFF)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_op      (req_op),
   .req_addr    (req_addr),
   .snoop_we    (snoop_we),
   .snoop_addr  (snoop_addr),
   .resv_clear  (resv_clear),
   .rsp_ready   (rsp_ready),
   .rsp_sc_fail (rsp_sc_fail),
   .resv_valid  (resv_valid),
   .resv_line   (resv_line)
);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;

   localparam int ADDR_W = 10;
   localparam int DATA_W = 32;
   localparam int WORDS  = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [1:0]        req_op = 2'b00;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              snoop_we = 1'b0;
   logic [ADDR_W-1:0] snoop_addr = '0;
   logic              resv_clear = 1'b0;
   logic              rsp_ready;
   logic [DATA_W-1:0] rsp_rdata;
   logic              rsp_sc_fail;

   always #4 clk = ~clk;

   lrsc_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(64)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .snoop_we(snoop_we),
      .snoop_addr(snoop_addr), .resv_clear(resv_clear), .rsp_ready(rsp_ready),
      .rsp_rdata(rsp_rdata), .rsp_sc_fail(rsp_sc_fail));

   typedef struct {
      logic [DATA_W-1:0] rd;
      logic              fail;
      string             tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 0;

   logic [DATA_W-1:0] mem_m [WORDS];
   bit                m_valid = 0;
   int                m_line = 0;

   function automatic int ln(input logic [ADDR_W-1:0] a);
      return int'(a >> 6);
   endfunction

   // Drive one cycle at the falling edge; predict the response.
   task automatic step(input bit v, input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd, input bit sw,
                       input logic [ADDR_W-1:0] sa, input bit trap, input string tag);
      exp_t e;
      bit   snoop_held;
      bit   ok;
      snoop_held = sw && m_valid && (ln(sa) == m_line);
      if (v) begin
         e.tag  = tag;
         e.rd   = '0;
         e.fail = 1'b0;
         case (op)
            2'b00, 2'b10: e.rd = mem_m[a >> 2];
            2'b01: mem_m[a >> 2] = wd;
            default: begin
               ok = m_valid && (ln(a) == m_line) && !trap && !snoop_held;
               if (ok) mem_m[a >> 2] = wd;
               e.fail = !ok;
            end
         endcase
         exp_q.push_back(e);
      end
      if (trap) m_valid = 0;
      else if (v && op == 2'b10) begin
         m_valid = !(sw && ln(sa) == ln(a));
         m_line  = ln(a);
      end else begin
         if (v && op == 2'b11) m_valid = 0;
         if (v && op == 2'b01 && ln(a) == m_line) m_valid = 0;
         if (snoop_held) m_valid = 0;
      end
      req_valid = v; req_op = op; req_addr = a; req_wdata = wd;
      snoop_we = sw; snoop_addr = sa; resv_clear = trap;
      @(negedge clk);
      req_valid = 0; snoop_we = 0; resv_clear = 0;
   endtask

   task automatic rq(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] wd, input string tag);
      step(1, op, a, wd, 0, '0, 0, tag);
   endtask

   // Monitor: each ready pulse pops one expected response.
   always @(negedge clk) begin
      if (rst_n && rsp_ready) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R9 unexpected ready: act ready=1 exp ready=0");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (rsp_rdata !== e.rd || rsp_sc_fail !== e.fail) begin
               bad++;
               $display("FAIL %s: act rdata=%h fail=%b exp rdata=%h fail=%b",
                        e.tag, rsp_rdata, rsp_sc_fail, e.rd, e.fail);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: act running exp finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < WORDS; i++) mem_m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (rsp_ready !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset ready: act %b exp 0", rsp_ready);
      end
      rq(2'b00, 10'h3FC, '0, "R11 memory zero after reset");
      rq(2'b11, 10'h000, 32'hDEAD, "R11 no reservation after reset");
      rq(2'b00, 10'h000, '0, "R2 refused store left memory");
      step(0, 2'b00, '0, '0, 0, '0, 0, "idle");
      // R1/R2/R3 basic success
      rq(2'b01, 10'h084, 32'h1111_2222, "R9 plain store response");
      rq(2'b10, 10'h084, '0, "R1 reserving load data");
      rq(2'b11, 10'h084, 32'hA5A5_0001, "R3 conditional store success");
      rq(2'b00, 10'h084, '0, "R2 successful store visible");
      // R5: second SC without new LR fails
      rq(2'b11, 10'h084, 32'hBAD0, "R5 reservation consumed");
      rq(2'b00, 10'h084, '0, "R5 memory unchanged");
      // R12 offsets within line and word
      rq(2'b10, 10'h083, '0, "R12 reserving load odd byte");
      rq(2'b11, 10'h0BE, 32'h0C0F_FEE0, "R12 other word same line");
      rq(2'b00, 10'h0BD, '0, "R12 word readback by byte address");
      // R4 snoop other line keeps, same line kills
      rq(2'b10, 10'h100, '0, "R1 arm line 4");
      step(0, 2'b00, '0, '0, 1, 10'h140, 0, "snoop other");
      rq(2'b11, 10'h104, 32'h4444, "R4 snoop elsewhere harmless");
      rq(2'b10, 10'h100, '0, "R1 re-arm line 4");
      step(0, 2'b00, '0, '0, 1, 10'h13F, 0, "snoop last byte");
      rq(2'b11, 10'h104, 32'h5555, "R4 snoop in line kills");
      rq(2'b00, 10'h104, '0, "R4 memory unchanged");
      // R6 replacement
      rq(2'b10, 10'h200, '0, "R6 arm line 8");
      rq(2'b10, 10'h240, '0, "R6 arm line 9");
      rq(2'b11, 10'h200, 32'h6666, "R6 old line refused");
      rq(2'b10, 10'h200, '0, "R6 arm line 8 again");
      rq(2'b10, 10'h240, '0, "R6 arm line 9 again");
      rq(2'b11, 10'h244, 32'h7777, "R6 newest line accepted");
      // R7 trap
      rq(2'b10, 10'h300, '0, "R7 arm");
      step(0, 2'b00, '0, '0, 0, '0, 1, "trap");
      rq(2'b11, 10'h300, 32'h8888, "R7 trap cleared");
      rq(2'b10, 10'h300, '0, "R7 arm again");
      step(1, 2'b11, 10'h300, 32'h9999, 0, '0, 1, "R7 trap same cycle refuses");
      // R8 own stores
      rq(2'b10, 10'h380, '0, "R8 arm line 14");
      rq(2'b01, 10'h3C0, 32'h1234, "R8 store other line");
      rq(2'b11, 10'h380, 32'hAAAA, "R8 other-line store harmless");
      rq(2'b10, 10'h380, '0, "R8 arm again");
      rq(2'b01, 10'h3BC, 32'h5678, "R8 store in line");
      rq(2'b11, 10'h380, 32'hBBBB, "R8 own store kills");
      // R10 race
      rq(2'b10, 10'h040, '0, "R10 arm line 1");
      step(1, 2'b11, 10'h040, 32'hCCCC, 1, 10'h07C, 0, "R10 snoop beats SC");
      rq(2'b00, 10'h040, '0, "R10 memory unchanged");
      rq(2'b10, 10'h040, '0, "R10 arm again");
      step(1, 2'b11, 10'h040, 32'hDDDD, 1, 10'h080, 0, "R10 snoop elsewhere same cycle");
      rq(2'b00, 10'h040, '0, "R9 load after race");
      // LR with snoop on its own line does not arm
      step(1, 2'b10, 10'h000, '0, 1, 10'h010, 0, "R4 LR with snoop same line");
      rq(2'b11, 10'h000, 32'hEEEE, "R4 LR killed by concurrent snoop");
      repeat (3) step(0, 2'b00, '0, '0, 0, '0, 0, "idle");
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R9 missing responses: act %0d pending exp 0", exp_q.size());
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule